// File: doc/BRIEF.md
# CAN Error Status and Interrupt Register Block

This block sits between a CAN protocol engine and a 16-bit host register port. It holds four host-visible words: a control word with three interrupt enables, a status word with the bus-state flags, the transmit-ok and receive-ok flags and a last-error code, a snapshot of the transmit and receive error counters, and an interrupt identifier. The protocol engine drives level inputs for the bus-state flags and short strobes for bus events, frame completions and counter updates. It also drives a vector of message-object interrupt requests. The block only latches, encodes and prioritises these inputs.

The host reads any word combinationally through the port. Writes go to the control and status words. A status interrupt condition is latched from completion events and from changes of bus state. While that condition is pending, the identifier shows a fixed status code. Otherwise it shows the lowest-numbered message object that is asking for service. A read of the status word clears the latched condition. The host can write the "unused" error code into the status word. It can then tell later whether any bus event has occurred since that write.

Top module: `can_stat_irq_regs`

## Requirements
- R1: After reset, all four words read 0x0000 and `irq` is low. Word addresses: 0 control, 1 status, 2 error counters, 3 interrupt identifier.
- R2: Status bit 7 (bus-off), bit 6 (warning) and bit 5 (passive) show the engine's level inputs one clock after those inputs change.
- R3: A pulse on `ev_txok` sets status bit 3 and a pulse on `ev_rxok` sets status bit 4. Both bits stay set until a host write to the status word carries a 0 in that bit position. A 1 written there leaves the bit unchanged. If a set pulse and a clearing write fall in the same cycle, the set wins.
- R4: Status bits 2:0 hold the last-error code (0 none, 1 stuff, 2 form, 3 acknowledge, 4 bit-1, 5 bit-0, 6 CRC, 7 unused). An `ev_valid` strobe loads `ev_lec`. A host write to the status word loads its bits 2:0. The field holds its value in every other cycle, so a written 7 persists until the next bus event.
- R5: A `cnt_valid` strobe loads the error-counter word: bits 7:0 take the transmit count, bits 14:8 the receive count and bit 15 the receive-passive flag. Between strobes the word holds its value.
- R6: With control bit 2 set, an `ev_txok` or `ev_rxok` pulse raises the status interrupt condition. With control bit 2 clear, those pulses do not raise it.
- R7: With control bit 3 set, a change of the bus-off input or the warning input raises the status interrupt condition. A change of the passive input does not raise it.
- R8: A host read of the status word clears the status interrupt condition. If a new raise happens in the same cycle, the condition stays pending.
- R9: The identifier reads 0x8000 while the status condition is pending. Otherwise it reads i+1, where i is the lowest set bit of `obj_pend`, or 0 when no bit is set.
- R10: Only control bits 3:1 are writable. All other control bits read 0. `irq` is high exactly when control bit 1 is set and the identifier is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Word address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the addressed word |
| ev_valid | input | 1 | Bus event detected, load the last-error code |
| ev_lec | input | 3 | Error code that goes with `ev_valid` |
| ev_txok | input | 1 | Frame transmitted successfully |
| ev_rxok | input | 1 | Frame received successfully |
| eng_boff | input | 1 | Engine is bus-off |
| eng_ewarn | input | 1 | Engine has reached the warning limit |
| eng_epass | input | 1 | Engine is error passive |
| cnt_valid | input | 1 | Counter snapshot strobe |
| cnt_tec | input | TEC_W | Transmit error count |
| cnt_rec | input | REC_W | Receive error count |
| cnt_rp | input | 1 | Receive-passive flag |
| obj_pend | input | NUM_OBJ | Message-object interrupt requests; bit i is object i+1 |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bench aims at same-cycle collisions. In one case a status read meets a new raise; a design that let the clear win would lose an interrupt. In another, a clearing write meets a TX-ok pulse; a design with the wrong priority would drop a completion. It holds the "unused" error code across idle cycles and then sends a bus event. An error field that decays, or that ignores the event, would hide bus activity from the host. It drives several object-request patterns, including the top object and multiple requests while a status condition is pending. A priority encoder that picks the highest bit, or lets an object mask the status code, shows up as a wrong identifier. It also toggles the passive input with the error enable on, and sends completions with the status enable off. Either case would raise a false interrupt if the enables were mis-wired.

// File: rtl/can_sir_pkg.sv
package can_sir_pkg;

   typedef enum logic [1:0] {
      RA_CTRL  = 2'd0,
      RA_STAT  = 2'd1,
      RA_ERRC  = 2'd2,
      RA_INTID = 2'd3
   } reg_addr_e;

   typedef enum logic [2:0] {
      LEC_NONE   = 3'd0,
      LEC_STUFF  = 3'd1,
      LEC_FORM   = 3'd2,
      LEC_ACK    = 3'd3,
      LEC_BIT1   = 3'd4,
      LEC_BIT0   = 3'd5,
      LEC_CRC    = 3'd6,
      LEC_UNUSED = 3'd7
   } lec_e;

   localparam int BIT_BOFF  = 7;
   localparam int BIT_EWARN = 6;
   localparam int BIT_EPASS = 5;
   localparam int BIT_RXOK  = 4;
   localparam int BIT_TXOK  = 3;

   localparam int CTRL_IE  = 1;
   localparam int CTRL_SIE = 2;
   localparam int CTRL_EIE = 3;

   localparam logic [15:0] INTID_STATUS = 16'h8000;

endpackage

// File: rtl/can_sir_status.sv
module can_sir_status
   import can_sir_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ev_valid,
   input  logic [2:0]  ev_lec,
   input  logic        ev_txok,
   input  logic        ev_rxok,
   input  logic        eng_boff,
   input  logic        eng_ewarn,
   input  logic        eng_epass,
   input  logic        wr_en,
   input  logic        wr_txok,
   input  logic        wr_rxok,
   input  logic [2:0]  wr_lec,
   input  logic        rd_en,
   input  logic        sie,
   input  logic        eie,
   output logic [15:0] stat_word,
   output logic        st_set,
   output logic        st_pend
);

   logic       boff_q, ewarn_q, epass_q;
   logic       txok_q, rxok_q;
   lec_e       lec_q;
   logic       bus_change;

   // only bus-off and warning transitions count as error-change events
   assign bus_change = (eng_boff ^ boff_q) | (eng_ewarn ^ ewarn_q);
   assign st_set     = (sie & (ev_txok | ev_rxok)) | (eie & bus_change);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boff_q  <= 1'b0;
         ewarn_q <= 1'b0;
         epass_q <= 1'b0;
         txok_q  <= 1'b0;
         rxok_q  <= 1'b0;
         lec_q   <= LEC_NONE;
         st_pend <= 1'b0;
      end else begin
         boff_q  <= eng_boff;
         ewarn_q <= eng_ewarn;
         epass_q <= eng_epass;
         // a set pulse wins over a clearing write in the same cycle
         txok_q  <= ev_txok | (wr_en ? (txok_q & wr_txok) : txok_q);
         rxok_q  <= ev_rxok | (wr_en ? (rxok_q & wr_rxok) : rxok_q);
         if (ev_valid)
            lec_q <= lec_e'(ev_lec);
         else if (wr_en)
            lec_q <= lec_e'(wr_lec);
         st_pend <= st_set | (st_pend & ~rd_en);
      end
   end

   always_comb begin
      stat_word            = '0;
      stat_word[BIT_BOFF]  = boff_q;
      stat_word[BIT_EWARN] = ewarn_q;
      stat_word[BIT_EPASS] = epass_q;
      stat_word[BIT_RXOK]  = rxok_q;
      stat_word[BIT_TXOK]  = txok_q;
      stat_word[2:0]       = lec_q;
   end

endmodule

// File: rtl/can_sir_errcnt.sv
module can_sir_errcnt #(
   parameter int TEC_W = 8,
   parameter int REC_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_valid,
   input  logic [TEC_W-1:0] cnt_tec,
   input  logic [REC_W-1:0] cnt_rec,
   input  logic             cnt_rp,
   output logic [15:0]      err_word
);

   localparam int PAD_W = 15 - TEC_W - REC_W;

   logic [TEC_W-1:0] tec_q;
   logic [REC_W-1:0] rec_q;
   logic             rp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tec_q <= '0;
         rec_q <= '0;
         rp_q  <= 1'b0;
      end else if (cnt_valid) begin
         tec_q <= cnt_tec;
         rec_q <= cnt_rec;
         rp_q  <= cnt_rp;
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign err_word = {rp_q, {PAD_W{1'b0}}, rec_q, tec_q};
      end else begin : g_tight
         assign err_word = {rp_q, rec_q, tec_q};
      end
   endgenerate

endmodule

// File: rtl/can_sir_intid.sv
module can_sir_intid
   import can_sir_pkg::*;
#(
   parameter int NUM_OBJ = 32
) (
   input  logic               st_pend,
   input  logic [NUM_OBJ-1:0] obj_pend,
   output logic [15:0]        intid
);

   logic [NUM_OBJ:0]   seen;
   logic [NUM_OBJ-1:0] first;
   logic [15:0]        obj_num;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_OBJ; i++) begin : g_chain
         assign first[i]  = obj_pend[i] & ~seen[i];
         assign seen[i+1] = seen[i] | obj_pend[i];
      end
   endgenerate

   always_comb begin
      obj_num = '0;
      for (int i = 0; i < NUM_OBJ; i++) begin
         if (first[i])
            obj_num = obj_num | 16'(i + 1);
      end
   end

   assign intid = st_pend ? INTID_STATUS : obj_num;

endmodule

// File: rtl/can_stat_irq_regs.sv
module can_stat_irq_regs
   import can_sir_pkg::*;
#(
   parameter int NUM_OBJ = 32,
   parameter int TEC_W   = 8,
   parameter int REC_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_sel,
   input  logic               host_wr,
   input  logic [1:0]         host_addr,
   input  logic [15:0]        host_wdata,
   output logic [15:0]        host_rdata,
   input  logic               ev_valid,
   input  logic [2:0]         ev_lec,
   input  logic               ev_txok,
   input  logic               ev_rxok,
   input  logic               eng_boff,
   input  logic               eng_ewarn,
   input  logic               eng_epass,
   input  logic               cnt_valid,
   input  logic [TEC_W-1:0]   cnt_tec,
   input  logic [REC_W-1:0]   cnt_rec,
   input  logic               cnt_rp,
   input  logic [NUM_OBJ-1:0] obj_pend,
   output logic               irq
);

   generate
      if (NUM_OBJ < 1 || NUM_OBJ > 32767) begin : g_bad_obj
         $error("NUM_OBJ must fit below the status identifier code");
      end
      if (TEC_W < 1 || REC_W < 1 || TEC_W + REC_W > 15) begin : g_bad_cnt
         $error("error counters must fit in bits 14:0");
      end
   endgenerate

   reg_addr_e   addr;
   logic        wr_stat, wr_ctrl, rd_stat;
   logic [3:1]  ctrl_q;
   logic        mod_ie;
   logic [15:0] stat_word, err_word, intid;
   logic        st_set, st_pend;
   logic        unused_wdata;

   assign addr         = reg_addr_e'(host_addr);
   assign wr_stat      = host_sel &  host_wr & (addr == RA_STAT);
   assign wr_ctrl      = host_sel &  host_wr & (addr == RA_CTRL);
   assign rd_stat      = host_sel & ~host_wr & (addr == RA_STAT);
   assign mod_ie       = ctrl_q[CTRL_IE];
   assign unused_wdata = ^{host_wdata[15:5], host_wdata[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_ctrl)
         ctrl_q <= host_wdata[3:1];
   end

   can_sir_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_valid  (ev_valid),
      .ev_lec    (ev_lec),
      .ev_txok   (ev_txok),
      .ev_rxok   (ev_rxok),
      .eng_boff  (eng_boff),
      .eng_ewarn (eng_ewarn),
      .eng_epass (eng_epass),
      .wr_en     (wr_stat),
      .wr_txok   (host_wdata[BIT_TXOK]),
      .wr_rxok   (host_wdata[BIT_RXOK]),
      .wr_lec    (host_wdata[2:0]),
      .rd_en     (rd_stat),
      .sie       (ctrl_q[CTRL_SIE]),
      .eie       (ctrl_q[CTRL_EIE]),
      .stat_word (stat_word),
      .st_set    (st_set),
      .st_pend   (st_pend)
   );

   can_sir_errcnt #(.TEC_W(TEC_W), .REC_W(REC_W)) u_errc (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_valid (cnt_valid),
      .cnt_tec   (cnt_tec),
      .cnt_rec   (cnt_rec),
      .cnt_rp    (cnt_rp),
      .err_word  (err_word)
   );

   can_sir_intid #(.NUM_OBJ(NUM_OBJ)) u_intid (
      .st_pend  (st_pend),
      .obj_pend (obj_pend),
      .intid    (intid)
   );

   always_comb begin
      case (addr)
         RA_CTRL:  host_rdata = {12'h000, ctrl_q, 1'b0};
         RA_STAT:  host_rdata = stat_word;
         RA_ERRC:  host_rdata = err_word;
         default:  host_rdata = intid;
      endcase
   end

   assign irq = mod_ie & (intid != 16'h0000);

endmodule

// File: rtl/can_sir_chk.sv
module can_sir_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ev_txok,
   input logic        ev_valid,
   input logic        cnt_valid,
   input logic        wr_stat,
   input logic        rd_stat,
   input logic        st_set,
   input logic        st_pend,
   input logic [15:0] stat_word,
   input logic [15:0] err_word,
   input logic [15:0] intid,
   input logic        mod_ie,
   input logic        irq
);

   // R9
   status_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_pend |-> intid == 16'h8000);

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> mod_ie);

   // R8
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !st_set) |=> !st_pend);

   // R3
   txok_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_txok |=> stat_word[3]);

   // R4
   lec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid && !wr_stat) |=> $stable(stat_word[2:0]));

   // R5
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_valid |=> $stable(err_word));

endmodule

bind can_stat_irq_regs can_sir_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_txok   (ev_txok),
   .ev_valid  (ev_valid),
   .cnt_valid (cnt_valid),
   .wr_stat   (wr_stat),
   .rd_stat   (rd_stat),
   .st_set    (st_set),
   .st_pend   (st_pend),
   .stat_word (stat_word),
   .err_word  (err_word),
   .intid     (intid),
   .mod_ie    (mod_ie),
   .irq       (irq)
);

// File: tb/sim_can_stat_irq_regs.sv
module sim_can_stat_irq_regs;

   localparam int NOBJ = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 0, host_wr = 0;
   logic [1:0]  host_addr = 0;
   logic [15:0] host_wdata = 0;
   logic [15:0] host_rdata;
   logic        ev_valid = 0, ev_txok = 0, ev_rxok = 0;
   logic [2:0]  ev_lec = 0;
   logic        eng_boff = 0, eng_ewarn = 0, eng_epass = 0;
   logic        cnt_valid = 0, cnt_rp = 0;
   logic [7:0]  cnt_tec = 0;
   logic [6:0]  cnt_rec = 0;
   logic [NOBJ-1:0] obj_pend = 0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model of host-visible state
   logic [3:1] m_ctrl;
   logic m_boff, m_ewarn, m_epass, m_txok, m_rxok, m_pend, m_rp;
   logic [2:0] m_lec;
   logic [7:0] m_tec;
   logic [6:0] m_rec;

   always #4 clk = ~clk;

   can_stat_irq_regs u0 (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ev_valid(ev_valid), .ev_lec(ev_lec), .ev_txok(ev_txok), .ev_rxok(ev_rxok),
      .eng_boff(eng_boff), .eng_ewarn(eng_ewarn), .eng_epass(eng_epass),
      .cnt_valid(cnt_valid), .cnt_tec(cnt_tec), .cnt_rec(cnt_rec), .cnt_rp(cnt_rp),
      .obj_pend(obj_pend), .irq(irq)
   );

   function automatic logic [15:0] lowest_obj(input logic [NOBJ-1:0] v);
      logic [15:0] r = 16'h0000;
      for (int i = NOBJ - 1; i >= 0; i--)
         if (v[i]) r = 16'(i + 1);
      return r;
   endfunction

   function automatic logic [15:0] exp_reg(input logic [1:0] a);
      case (a)
         2'd0:    return {12'h000, m_ctrl, 1'b0};
         2'd1:    return {8'h00, m_boff, m_ewarn, m_epass, m_rxok, m_txok, m_lec};
         2'd2:    return {m_rp, m_rec, m_tec};
         default: return m_pend ? 16'h8000 : lowest_obj(obj_pend);
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ctrl = 0; m_boff = 0; m_ewarn = 0; m_epass = 0; m_txok = 0;
      m_rxok = 0; m_pend = 0; m_rp = 0; m_lec = 0; m_tec = 0; m_rec = 0;
   endtask

   // one clock: advance model with the inputs in force, then clear strobes
   task automatic step();
      logic ws, wc, rs, set;
      ws  = host_sel &  host_wr & (host_addr == 2'd1);
      wc  = host_sel &  host_wr & (host_addr == 2'd0);
      rs  = host_sel & ~host_wr & (host_addr == 2'd1);
      set = (m_ctrl[2] & (ev_txok | ev_rxok)) |
            (m_ctrl[3] & ((eng_boff != m_boff) | (eng_ewarn != m_ewarn)));
      @(posedge clk);
      m_pend = set | (m_pend & ~rs);
      m_txok = ev_txok | (ws ? (m_txok & host_wdata[3]) : m_txok);
      m_rxok = ev_rxok | (ws ? (m_rxok & host_wdata[4]) : m_rxok);
      if (ev_valid) m_lec = ev_lec;
      else if (ws)  m_lec = host_wdata[2:0];
      if (wc) m_ctrl = host_wdata[3:1];
      if (cnt_valid) begin m_tec = cnt_tec; m_rec = cnt_rec; m_rp = cnt_rp; end
      m_boff = eng_boff; m_ewarn = eng_ewarn; m_epass = eng_epass;
      @(negedge clk);
      host_sel = 0; host_wr = 0; ev_valid = 0; ev_txok = 0; ev_rxok = 0; cnt_valid = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
      step();
   endtask

   // read one word and compare; the read itself takes a clock
   task automatic check_reg(input string tag, input logic [1:0] a);
      logic [15:0] e;
      e = exp_reg(a);
      host_sel = 1; host_wr = 0; host_addr = a;
      #1;
      chk(tag, host_rdata, e);
      step();
   endtask

   task automatic check_irq(input string tag);
      logic e;
      #1;
      e = m_ctrl[1] & (exp_reg(2'd3) != 16'h0000);
      chk(tag, {15'h0, irq}, {15'h0, e});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check_irq("R1 irq");
      check_reg("R1 intid", 2'd3);
      check_reg("R1 ctrl", 2'd0);
      check_reg("R1 errc", 2'd2);
      check_reg("R1 status", 2'd1);

      // R10 only bits 3:1 writable
      wr(2'd0, 16'hFFFF);
      check_reg("R10 ctrl mask", 2'd0);
      wr(2'd0, 16'h0008);            // error enable only

      // R2 bus-state levels; R7 bus-off change raises
      eng_boff = 1; step();
      check_reg("R2 boff bit7", 2'd1);  // read clears
      // R7 passive change does not raise
      eng_epass = 1; step();
      check_reg("R7 epass no raise", 2'd3);
      check_reg("R2 epass bit5", 2'd1);
      eng_ewarn = 1; step();
      check_reg("R7 ewarn raise", 2'd3);
      check_reg("R2 ewarn bit6", 2'd1);
      eng_boff = 0; eng_ewarn = 0; eng_epass = 0; step();
      check_reg("R8 clear after read", 2'd1);
      check_reg("R8 intid idle", 2'd3);

      // R6 completions with status enable off
      ev_txok = 1; step();
      check_reg("R6 no raise sie off", 2'd3);
      check_reg("R3 txok set", 2'd1);
      wr(2'd0, 16'h0006);            // status enable + module enable
      ev_rxok = 1; step();
      check_irq("R10 irq on pending");
      check_reg("R6 raise sie on", 2'd3);
      // R3 writing ones keeps, zeros clear
      wr(2'd1, 16'h0018);
      check_reg("R3 write ones keep", 2'd1);
      wr(2'd1, 16'h0010);
      check_reg("R3 clear txok only", 2'd1);
      // R3 set wins over a clearing write
      host_sel = 1; host_wr = 1; host_addr = 2'd1; host_wdata = 16'h0000; ev_rxok = 1;
      step();
      check_reg("R3 set beats clear", 2'd1);
      // R8 read meets raise: stays pending
      host_sel = 1; host_wr = 0; host_addr = 2'd1; ev_txok = 1;
      step();
      check_reg("R8 raise beats clear", 2'd3);
      check_reg("R8 read clear", 2'd1);

      // R4 unused code persists until a bus event
      wr(2'd1, 16'h0007);
      repeat (5) step();
      check_reg("R4 unused held", 2'd1);
      ev_valid = 1; ev_lec = 3'd3; step();
      check_reg("R4 event loads", 2'd1);

      // R5 counters
      cnt_valid = 1; cnt_tec = 8'hA5; cnt_rec = 7'h5A; cnt_rp = 1; step();
      cnt_tec = 8'h11;
      step();
      check_reg("R5 counter fields", 2'd2);

      // R9 object identifiers
      obj_pend = 32'h0000_0001; check_reg("R9 obj1", 2'd3);
      obj_pend = 32'h0000_0220; check_reg("R9 lowest of two", 2'd3);
      obj_pend = 32'h8000_0000; check_reg("R9 top obj", 2'd3);
      check_irq("R10 irq object");
      wr(2'd0, 16'h0004);
      check_irq("R10 irq gated off");
      ev_txok = 1; step();
      check_reg("R9 status over objects", 2'd3);
      check_reg("R9 status read", 2'd1);
      obj_pend = '0; check_reg("R9 none", 2'd3);

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         ev_valid  = ($urandom % 4) == 0;
         ev_lec    = 3'($urandom);
         ev_txok   = ($urandom % 5) == 0;
         ev_rxok   = ($urandom % 5) == 0;
         if (($urandom % 8) == 0) eng_boff  = ~eng_boff;
         if (($urandom % 8) == 0) eng_ewarn = ~eng_ewarn;
         if (($urandom % 8) == 0) eng_epass = ~eng_epass;
         cnt_valid = ($urandom % 6) == 0;
         cnt_tec   = 8'($urandom);
         cnt_rec   = 7'($urandom);
         cnt_rp    = 1'($urandom);
         obj_pend  = $urandom & $urandom & $urandom;
         op = $urandom % 4;
         if (op == 0) wr(2'd0, 16'($urandom));
         else if (op == 1) wr(2'd1, 16'($urandom));
         else if (op == 2) check_reg("RND read", 2'($urandom));
         else step();
         check_irq("RND irq");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule